// File: doc/BRIEF.md
# Resume-Well Power Event Status and Routing

This block keeps sticky event status for a power-management controller that lives in the always-on resume power well. Each event input is active-low. It passes through a two-flop synchronizer, and an edge detector sets a status bit on each new assertion. Each status bit that can signal has a matching enable bit. When an enabled status bit is set, the block raises one of three level outputs. While the system is awake, this is an interrupt to the operating system or a management interrupt. While the system is asleep, it is a wake request.

The output chosen depends on the sleep state, an interrupt-select input, and a flag that tells whether soft-off was entered by a software command or by a power-button override or power loss. A thermal-override status bit records its event but has no enable bit and never signals. The battery-low bit exists only in the mobile build option. Software reads and writes two registers through a simple port. Status bits clear only when software writes a one to them. Only the resume-well reset clears the registers.

Top module: `pm_event_block`

## Requirements
- R1: After `resume_rst_n` is asserted, the status register (address 0) and the enable register (address 1) read 0x0000, and `wake_req`, `sci_irq` and `smi_irq` are low.
- R2: A high-to-low transition on an event input sets its status bit on the third rising clock edge after the input changes. The bit layout is: bit 0 `pme_n`, bit 1 `batlow_n`, bit 2 `therm_n`, and bits 3 to 6 `gpe_n[0..3]`. A held low level sets the bit only once: if software clears the bit while the input stays low, it stays clear.
- R3: A write to address 0 clears each status bit whose data bit is 1. Data bits of 0 leave the status unchanged.
- R4: If a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: With `slp_state` = 0 (working), a set and enabled status bit drives `sci_irq` when `sci_sel` = 1, and drives `smi_irq` when `sci_sel` = 0. `wake_req` stays low.
- R6: With `slp_state` from 1 to 4, or with `slp_state` = 5 and `soft_off_hw` = 0, a set and enabled status bit drives `wake_req` and neither interrupt. When `slp_state` returns to 0, the interrupt chosen by `sci_sel` rises, as long as the bit is still set.
- R7: With `slp_state` = 5 and `soft_off_hw` = 1, events still set status, but all three outputs stay low.
- R8: The thermal-override bit (status bit 2) sets on its event, but enable bit 2 always reads 0 and the bit never drives any output.
- R9: With `MOBILE` = 0, status bit 1 and enable bit 1 always read 0, even after a `batlow_n` event or a write of 1.
- R10: Reserved bits 7 to 15 of both registers always read 0, and writes to them have no effect.
- R11: The outputs are levels. They stay high while any enabled status bit routed to them is set, and they drop once that status bit is cleared or its enable bit is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-well clock |
| resume_rst_n | input | 1 | Asynchronous active-low resume-well reset |
| pme_n | input | 1 | Power-management event request, active low |
| batlow_n | input | 1 | Battery-low indication, active low (mobile option) |
| therm_n | input | 1 | Thermal override indication, active low |
| gpe_n | input | GP_COUNT | General event inputs, active low |
| slp_state | input | 3 | Current sleep state: 0 working, 1-4 sleeping, 5 soft-off |
| soft_off_hw | input | 1 | Soft-off was caused by power-button override or power loss |
| sci_sel | input | 1 | 1 routes working-state events to `sci_irq`, 0 to `smi_irq` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data of the selected register |
| wake_req | output | 1 | Wake request level |
| sci_irq | output | 1 | Operating-system interrupt level |
| smi_irq | output | 1 | Management interrupt level |

## Verification
Suppose a status or enable flop holds a wrong value. The read port shows it in the same cycle the register is selected. The routed outputs show it combinationally, as soon as the matching enable is set and the sleep state selects a path. A broken synchronizer or edge detector moves the set into a different cycle than the third edge, or sets the bit again while the input stays low. The sweep checks status in exactly that cycle. Routing errors show up as the wrong output or a missing output for some combination of sleep state, select input and soft-off cause. Every such combination is driven for every event input, so these errors appear within one event pulse.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   typedef enum logic [2:0] {
      SLP_WORK = 3'd0,
      SLP_ONE  = 3'd1,
      SLP_TWO  = 3'd2,
      SLP_THR  = 3'd3,
      SLP_FOUR = 3'd4,
      SLP_OFF  = 3'd5
   } slp_e;

   localparam int BIT_PME    = 0;
   localparam int BIT_BATLOW = 1;
   localparam int BIT_THERM  = 2;
   localparam int BIT_GP0    = 3;
   localparam int FIXED_EVTS = 3;
endpackage

// File: rtl/pm_evt_sync.sv
module pm_evt_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_n,
   output logic [W-1:0] fall
);
   localparam int CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pm_evt_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [CHAIN-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[CHAIN-2:0], in_n[i]};
      end
      assign fall[i] = pipe[CHAIN-1] & ~pipe[CHAIN-2];
   end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs #(
   parameter int              REG_W    = 16,
   parameter logic [REG_W-1:0] STS_MASK = '1,
   parameter logic [REG_W-1:0] EN_MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [REG_W-1:0] hw_set,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] en_q
);
   logic [REG_W-1:0] clr;

   assign clr = (wr_en && !wr_addr) ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= ((sts_q & ~clr) | hw_set) & STS_MASK;
         if (wr_en && wr_addr) en_q <= wr_data & EN_MASK;
      end
   end
endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route #(
   parameter int REG_W = 16
) (
   input  logic [REG_W-1:0] sts,
   input  logic [REG_W-1:0] en,
   input  logic [2:0]       slp_state,
   input  logic             soft_off_hw,
   input  logic             sci_sel,
   output logic             wake_req,
   output logic             sci_irq,
   output logic             smi_irq
);
   import pm_evt_pkg::*;

   logic pend;
   assign pend = |(sts & en);

   always_comb begin
      wake_req = 1'b0;
      sci_irq  = 1'b0;
      smi_irq  = 1'b0;
      case (slp_state)
         SLP_WORK: begin
            sci_irq = pend & sci_sel;
            smi_irq = pend & ~sci_sel;
         end
         SLP_OFF:  wake_req = pend & ~soft_off_hw;
         default:  wake_req = pend;
      endcase
   end
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block #(
   parameter int REG_W    = 16,
   parameter int GP_COUNT = 4,
   parameter bit MOBILE   = 1'b1,
   parameter int SYNC_STG = 2
) (
   input  logic                clk,
   input  logic                resume_rst_n,
   input  logic                pme_n,
   input  logic                batlow_n,
   input  logic                therm_n,
   input  logic [GP_COUNT-1:0] gpe_n,
   input  logic [2:0]          slp_state,
   input  logic                soft_off_hw,
   input  logic                sci_sel,
   input  logic                reg_wr,
   input  logic                reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                wake_req,
   output logic                sci_irq,
   output logic                smi_irq
);
   import pm_evt_pkg::*;

   localparam int EVT_N = FIXED_EVTS + GP_COUNT;
   localparam logic [REG_W-1:0] ONE      = REG_W'(1);
   localparam logic [REG_W-1:0] GP_MASK  = ((ONE << GP_COUNT) - ONE) << BIT_GP0;
   localparam logic [REG_W-1:0] BAT_MASK = MOBILE ? (ONE << BIT_BATLOW) : '0;
   localparam logic [REG_W-1:0] STS_MASK = GP_MASK | BAT_MASK
                                         | (ONE << BIT_PME) | (ONE << BIT_THERM);
   localparam logic [REG_W-1:0] EN_MASK  = STS_MASK & ~(ONE << BIT_THERM);

   if (EVT_N > REG_W) begin : g_bad_width
      $error("pm_event_block: GP_COUNT does not fit in REG_W");
   end
   if (GP_COUNT < 1) begin : g_bad_gp
      $error("pm_event_block: GP_COUNT must be at least 1");
   end

   logic [EVT_N-1:0] evt_n, evt_fall;
   logic [REG_W-1:0] hw_set, sts_q, en_q;

   assign evt_n = {gpe_n, therm_n, batlow_n, pme_n};

   pm_evt_sync #(.W(EVT_N), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (resume_rst_n),
      .in_n  (evt_n),
      .fall  (evt_fall)
   );

   if (EVT_N == REG_W) begin : g_set_full
      assign hw_set = evt_fall;
   end else begin : g_set_ext
      assign hw_set = {{(REG_W-EVT_N){1'b0}}, evt_fall};
   end

   pm_evt_regs #(.REG_W(REG_W), .STS_MASK(STS_MASK), .EN_MASK(EN_MASK)) u_regs (
      .clk     (clk),
      .rst_n   (resume_rst_n),
      .wr_en   (reg_wr),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .hw_set  (hw_set),
      .sts_q   (sts_q),
      .en_q    (en_q)
   );

   assign reg_rdata = reg_addr ? en_q : sts_q;

   pm_evt_route #(.REG_W(REG_W)) u_route (
      .sts         (sts_q),
      .en          (en_q),
      .slp_state   (slp_state),
      .soft_off_hw (soft_off_hw),
      .sci_sel     (sci_sel),
      .wake_req    (wake_req),
      .sci_irq     (sci_irq),
      .smi_irq     (smi_irq)
   );
endmodule

// File: rtl/pm_event_block_chk.sv
module pm_event_block_chk #(
   parameter int               REG_W    = 16,
   parameter logic [REG_W-1:0] STS_MASK = '1,
   parameter int               THERM    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       slp_state,
   input logic             soft_off_hw,
   input logic             sci_sel,
   input logic             reg_wr,
   input logic             reg_addr,
   input logic [REG_W-1:0] sts_q,
   input logic [REG_W-1:0] en_q,
   input logic             wake_req,
   input logic             sci_irq,
   input logic             smi_irq
);
   // R3: without a status write, no status bit ever drops
   a_r3_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && !reg_addr) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

   // R5: no wake request while working
   a_r5_work_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_state == 3'd0) |-> !wake_req);

   // R6: no interrupts while sleeping
   a_r6_sleep_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_state != 3'd0) |-> (!sci_irq && !smi_irq));

   // R7: override/power-loss soft-off is silent
   a_r7_override_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_state == 3'd5 && soft_off_hw) |-> !(wake_req || sci_irq || smi_irq));

   // R8: thermal bit has no enable
   a_r8_therm_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[THERM]);

   // R10: unimplemented bits stay zero
   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_q | en_q) & ~STS_MASK) == '0);

   // R11: working-state level follows pending enabled status
   a_r11_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_state == 3'd0 && (|(sts_q & en_q))) |-> (sci_irq ^ smi_irq));

   // R5: at most one output at a time
   a_r5_single_path: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wake_req, sci_irq, smi_irq}));
endmodule

bind pm_event_block pm_event_block_chk #(
   .REG_W(REG_W), .STS_MASK(STS_MASK), .THERM(pm_evt_pkg::BIT_THERM)
) u_chk (
   .clk         (clk),
   .rst_n       (resume_rst_n),
   .slp_state   (slp_state),
   .soft_off_hw (soft_off_hw),
   .sci_sel     (sci_sel),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .sts_q       (sts_q),
   .en_q        (en_q),
   .wake_req    (wake_req),
   .sci_irq     (sci_irq),
   .smi_irq     (smi_irq)
);

// File: tb/pm_event_block_test.sv
`timescale 1ns/100ps
module pm_event_block_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evn = 7'h7F;
   logic [2:0]  slp = 3'd0;
   logic        hwoff = 1'b0, sel = 1'b0;
   logic        wr = 1'b0, addr = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata, rdata_d;
   logic        wake, sci, smi, wake_d, sci_d, smi_d;
   int          nvec = 0, nbad = 0;

   always #2.5 clk = ~clk;

   pm_event_block uut (
      .clk(clk), .resume_rst_n(rst_n), .pme_n(evn[0]), .batlow_n(evn[1]),
      .therm_n(evn[2]), .gpe_n(evn[6:3]), .slp_state(slp), .soft_off_hw(hwoff),
      .sci_sel(sel), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .wake_req(wake), .sci_irq(sci), .smi_irq(smi));

   pm_event_block #(.MOBILE(1'b0)) uut_desk (
      .clk(clk), .resume_rst_n(rst_n), .pme_n(evn[0]), .batlow_n(evn[1]),
      .therm_n(evn[2]), .gpe_n(evn[6:3]), .slp_state(slp), .soft_off_hw(hwoff),
      .sci_sel(sel), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata_d), .wake_req(wake_d), .sci_irq(sci_d), .smi_irq(smi_d));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [15:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic a, output logic [15:0] d, output logic [15:0] dd);
      addr = a;
      #0.5;
      d = rdata; dd = rdata_d;
   endtask

   function automatic logic [15:0] outs();
      return {13'd0, wake, sci, smi};
   endfunction

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] d, dd, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_reg(1'b0, d, dd); check("R1 status", d, 16'h0000);
      rd_reg(1'b1, d, dd); check("R1 enable", d, 16'h0000);
      check("R1 outputs", outs(), 16'h0000);

      // enable mask: therm, reserved and (desktop) battery-low stay zero
      wr_reg(1'b1, 16'hFFFF);
      rd_reg(1'b1, d, dd);
      check("R8 R10 enable readback", d, 16'h007B);
      check("R9 desktop enable readback", dd, 16'h0079);
      wr_reg(1'b0, 16'hFFFF);
      rd_reg(1'b0, d, dd);
      check("R10 status write ignored", d, 16'h0000);

      // sweep over every event, sleep state, soft-off cause and select
      for (int ev = 0; ev < 7; ev++)
         for (int st = 0; st < 6; st++)
            for (int hw = 0; hw < 2; hw++)
               for (int sl = 0; sl < 2; sl++) begin
                  logic sig, wk;
                  slp = 3'(st); hwoff = hw[0]; sel = sl[0];
                  evn[ev] = 1'b0;
                  repeat (3) @(negedge clk);
                  rd_reg(1'b0, d, dd);
                  check("R2 status set", d, 16'(1) << ev);
                  check("R9 desktop status", dd, (16'(1) << ev) & 16'hFFFD);
                  sig = (ev != 2);
                  wk  = sig && (st != 0) && !(st == 5 && hw == 1);
                  exp = {13'd0, wk, sig && st == 0 && sl == 1, sig && st == 0 && sl == 0};
                  if (ev == 2) check("R8 therm silent", outs(), exp);
                  else if (st == 0) check("R5 working route", outs(), exp);
                  else if (st == 5 && hw == 1) check("R7 override silent", outs(), exp);
                  else check("R6 sleep wake", outs(), exp);
                  if (wk) begin
                     slp = 3'd0;
                     #0.5;
                     check("R6 resume interrupt", outs(), {13'd0, 1'b0, sel, ~sel});
                  end
                  evn[ev] = 1'b1;
                  wr_reg(1'b0, 16'(1) << ev);
                  repeat (3) @(negedge clk);
                  rd_reg(1'b0, d, dd);
                  check("R3 w1c clears", d, 16'h0000);
                  check("R11 output drops", outs(), 16'h0000);
               end

      // R3: zero write keeps, one write clears only its bit
      slp = 3'd0; sel = 1'b1;
      evn[0] = 1'b0; evn[4] = 1'b0;
      repeat (3) @(negedge clk);
      evn[0] = 1'b1; evn[4] = 1'b1;
      wr_reg(1'b0, 16'h0000);
      rd_reg(1'b0, d, dd); check("R3 zero write keeps", d, 16'h0011);
      wr_reg(1'b0, 16'h0010);
      rd_reg(1'b0, d, dd); check("R3 one write clears bit", d, 16'h0001);

      // R11: clearing the enable drops the level, status stays
      check("R11 level high", outs(), 16'h0002);
      wr_reg(1'b1, 16'h0000);
      rd_reg(1'b0, d, dd);
      check("R11 enable off status kept", d, 16'h0001);
      check("R11 enable off drops", outs(), 16'h0000);
      wr_reg(1'b1, 16'hFFFF);
      wr_reg(1'b0, 16'h0001);

      // R2: a held low level does not set again after a clear
      evn[3] = 1'b0;
      repeat (3) @(negedge clk);
      wr_reg(1'b0, 16'h0008);
      repeat (5) @(negedge clk);
      rd_reg(1'b0, d, dd); check("R2 held level no reset", d, 16'h0000);
      evn[3] = 1'b1;
      repeat (4) @(negedge clk);

      // R4: set wins over same-cycle clear
      evn[5] = 1'b0;
      repeat (3) @(negedge clk);
      evn[5] = 1'b1;
      repeat (4) @(negedge clk);
      evn[5] = 1'b0;
      repeat (2) @(negedge clk);
      wr_reg(1'b0, 16'h0020);
      rd_reg(1'b0, d, dd); check("R4 set beats clear", d, 16'h0020);
      evn[5] = 1'b1;

      // R1: resume-well reset clears everything
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_reg(1'b0, d, dd); check("R1 reset status", d, 16'h0000);
      rd_reg(1'b1, d, dd); check("R1 reset enable", d, 16'h0000);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule